// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Controller

This block gathers five interrupt requests for a small 8-bit processor core. It reports a single pending indication together with a 3-bit code that names the highest-priority source allowed through. From the lowest priority to the highest, the sources are:

- a general-purpose request;
- three level-numbered restart requests, at levels 5.5, 6.5 and 7.5;
- a trap request.

The core controls the block through a small set of inputs:

- It writes a three-bit mask that can block each of the three restart levels.
- It sets and clears a global enable flag.
- It can discard a latched 7.5 request with a dedicated strobe.
- It answers a reported interrupt with a one-cycle acknowledge pulse.

The acknowledge drops the global enable. If the source being served is latched (7.5 or trap), the acknowledge also clears its pending bit.

The trap source cannot be masked or disabled. It must rise and then stay high for a second sample before it becomes pending. The 7.5 source is caught on a rising edge and is held until it is served or discarded. The general-purpose, 5.5 and 6.5 sources are level requests, seen as they are in each cycle. The identifier is decoded combinationally from the registered state and the current level inputs.

Top module: `irq_prio_ctrl`

## Requirements
- R1: `irq_id` names the highest-priority eligible source in the same cycle, coded as follows: 0 none, 1 general-purpose, 2 level 5.5, 3 level 6.5, 4 level 7.5, 5 trap. `irq_pending` is high exactly when `irq_id` is nonzero.
- R2: `ien_set` sets the global enable and `ien_clr` clears it, both at the next clock edge, with clear winning over set. While the enable is clear, codes 1 to 4 are never reported.
- R3: A pending trap is reported as code 5 regardless of the mask and of the global enable.
- R4: `mask_wr` loads `mask_wdata` at the next edge. Bit 0 blocks 5.5, bit 1 blocks 6.5 and bit 2 blocks 7.5, and a set bit blocks. The general-purpose request is not affected by the mask.
- R5: A 7.5 input that is low at one edge and high at the next sets the 7.5 pending bit. The bit stays set after the input falls, and holding the input high does not re-trigger it. The mask stops only the reporting of 7.5, not its capture.
- R6: `r75_clr`, or an acknowledge taken while the code is 4, clears the 7.5 pending bit. A capturing edge in the same cycle wins, and the bit stays set.
- R7: The trap becomes pending only when its input is high at two consecutive edges after a low one. A pulse that is high for a single edge never becomes pending. Once pending, the trap holds until acknowledged.
- R8: An acknowledge clears the global enable at the next edge, overriding `ien_set` in the same cycle. An acknowledge taken while the code is 5 clears the trap pending bit. Level sources are not cleared by an acknowledge.
- R9: A synchronous reset clears the global enable, sets all three mask bits and clears all pending state, so the code reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_gen | input | 1 | General-purpose level request |
| req_l55 | input | 1 | Level 5.5 request (level) |
| req_l65 | input | 1 | Level 6.5 request (level) |
| req_l75 | input | 1 | Level 7.5 request (rising edge) |
| req_trap | input | 1 | Trap request (edge and level qualified) |
| mask_wr | input | 1 | Load strobe for the mask |
| mask_wdata | input | 3 | New mask value: bit0 5.5, bit1 6.5, bit2 7.5 |
| ien_set | input | 1 | Set global enable |
| ien_clr | input | 1 | Clear global enable |
| r75_clr | input | 1 | Discard the latched 7.5 request |
| ack | input | 1 | One-cycle acknowledge from the core |
| irq_pending | output | 1 | Some source is being reported |
| irq_id | output | 3 | Code of the reported source |

## Verification
The two functions that can collide are the acknowledge, or the discard strobe, clearing the 7.5 pending bit, and a fresh 7.5 rising edge setting it in the same cycle. The acknowledge landing together with `ien_set` is a second collision.

Directed sequences line up these collisions on one edge. They are then judged by the code reported after the enable is raised again: code 4 must reappear, and the enable must stay clear after the acknowledge. The random phase drives acknowledges, strobes and request edges independently, so the same collisions recur many times. Each one is compared against a bench model of the pending, mask and enable state.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int SRC_N  = 5;
  localparam int ID_W   = $clog2(SRC_N + 1);
  localparam int MASK_W = SRC_N - 2;

  typedef enum logic [ID_W-1:0] {
    ID_NONE = 3'd0,
    ID_GEN  = 3'd1,
    ID_L55  = 3'd2,
    ID_L65  = 3'd3,
    ID_L75  = 3'd4,
    ID_TRAP = 3'd5
  } irq_id_e;

  // Highest set index wins; code is index plus one, zero when nothing set.
  function automatic logic [ID_W-1:0] pick_highest(input logic [SRC_N-1:0] elig);
    logic [ID_W-1:0] id;
    id = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (elig[i]) id = ID_W'(i + 1);
    end
    return id;
  endfunction
endpackage

// File: rtl/irq_mask_ien.sv
module irq_mask_ien #(
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_wdata,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              ack,
  output logic [MASK_W-1:0] mask_q,
  output logic              ien_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      ien_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      if (ack || ien_clr) ien_q <= 1'b0;
      else if (ien_set)   ien_q <= 1'b1;
    end
  end

  a_r8_ack_drops_ien: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ien_q);
  a_r2_set_raises_ien: assert property (@(posedge clk) disable iff (rst)
    (ien_set && !ien_clr && !ack) |=> ien_q);
  a_r4_mask_loads: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> (mask_q == $past(mask_wdata)));
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (!ien_q && (mask_q == '1)));
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic rise;

  assign rise = din && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= din;
      if (rise)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  a_r5_rise_latches: assert property (@(posedge clk) disable iff (rst)
    rise |=> pend);
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr && !rise) |=> !pend);
  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    (!pend && !rise) |=> !pend);
endmodule

// File: rtl/irq_trap_qual.sv
module irq_trap_qual (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic arm_q;
  logic fire;

  assign fire = arm_q && din;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      arm_q  <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= din;
      arm_q  <= din && !prev_q;
      if (fire)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  a_r7_needs_second_high: assert property (@(posedge clk) disable iff (rst)
    (!pend && !fire) |=> !pend);
  a_r7_holds_until_ack: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
  import irq_prio_pkg::*;
(
  input  logic [SRC_N-1:0] elig,
  output logic [ID_W-1:0]  id,
  output logic             any
);
  assign id  = pick_highest(elig);
  assign any = |elig;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_gen,
  input  logic              req_l55,
  input  logic              req_l65,
  input  logic              req_l75,
  input  logic              req_trap,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_wdata,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              r75_clr,
  input  logic              ack,
  output logic              irq_pending,
  output logic [ID_W-1:0]   irq_id
);
  logic [MASK_W-1:0] mask_q;
  logic              ien_q;
  logic              l75_pend;
  logic              trap_pend;
  logic              ack_l75;
  logic              ack_trap;
  logic [SRC_N-1:0]  raw;
  logic [SRC_N-1:0]  elig;

  // Acknowledge events, named so the assertions can see them.
  assign ack_l75  = ack && (irq_id == ID_L75);
  assign ack_trap = ack && (irq_id == ID_TRAP);

  irq_mask_ien #(.MASK_W(MASK_W)) u_regs (
    .clk(clk), .rst(rst), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .ien_set(ien_set), .ien_clr(ien_clr), .ack(ack),
    .mask_q(mask_q), .ien_q(ien_q)
  );

  irq_edge_latch u_l75 (
    .clk(clk), .rst(rst), .din(req_l75), .clr(r75_clr || ack_l75), .pend(l75_pend)
  );

  irq_trap_qual u_trap (
    .clk(clk), .rst(rst), .din(req_trap), .clr(ack_trap), .pend(trap_pend)
  );

  assign raw = {trap_pend, l75_pend, req_l65, req_l55, req_gen};

  for (genvar i = 0; i < SRC_N; i++) begin : g_gate
    if (i == SRC_N - 1) begin : g_nmi
      assign elig[i] = raw[i];
    end else if (i == 0) begin : g_plain
      assign elig[i] = raw[i] && ien_q;
    end else begin : g_masked
      assign elig[i] = raw[i] && ien_q && !mask_q[i-1];
    end
  end

  irq_prio_encoder u_enc (.elig(elig), .id(irq_id), .any(irq_pending));

  a_r3_trap_wins: assert property (@(posedge clk) disable iff (rst)
    trap_pend |-> (irq_id == ID_TRAP));
  a_r2_gated_when_off: assert property (@(posedge clk) disable iff (rst)
    !ien_q |-> (irq_id == ID_NONE || irq_id == ID_TRAP));
  a_r4_masked_l55_silent: assert property (@(posedge clk) disable iff (rst)
    (mask_q[0] && !req_gen && !req_l65 && !l75_pend && !trap_pend) |-> (irq_id == ID_NONE));
  a_r8_trap_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack_trap |=> (!trap_pend || $past(req_trap)));
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  logic clk = 0;
  logic rst = 1;
  logic rq_gen = 0, rq_55 = 0, rq_65 = 0, rq_75 = 0, rq_trap = 0;
  logic mwr = 0, iset = 0, iclr = 0, rclr = 0, ack = 0;
  logic [2:0] mdat = 3'b000;
  logic irq_pending;
  logic [2:0] irq_id;

  int checks = 0, failures = 0;
  bit done = 0;

  // Bench model of the controller state.
  bit m_ien, m_l75p, m_l75prev, m_tprev, m_tarm, m_tp;
  bit [2:0] m_mask;

  always #5 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst(rst), .req_gen(rq_gen), .req_l55(rq_55), .req_l65(rq_65),
    .req_l75(rq_75), .req_trap(rq_trap), .mask_wr(mwr), .mask_wdata(mdat),
    .ien_set(iset), .ien_clr(iclr), .r75_clr(rclr), .ack(ack),
    .irq_pending(irq_pending), .irq_id(irq_id)
  );

  function automatic bit [2:0] want_id();
    if (m_tp) return 3'd5;
    if (!m_ien) return 3'd0;
    if (m_l75p && !m_mask[2]) return 3'd4;
    if (rq_65 && !m_mask[1]) return 3'd3;
    if (rq_55 && !m_mask[0]) return 3'd2;
    if (rq_gen) return 3'd1;
    return 3'd0;
  endfunction

  task automatic chk(input string tag);
    bit [2:0] e;
    e = want_id();
    checks++;
    if (irq_id !== e || irq_pending !== (e != 0)) begin
      failures++;
      $display("FAIL %s: id=%0d pend=%0b expected id=%0d pend=%0b",
               tag, irq_id, irq_pending, e, (e != 0));
    end
  endtask

  task automatic model_edge();
    bit [2:0] e;
    bit rise, fire;
    e = want_id();
    if (rst) begin
      m_ien = 0; m_mask = 3'b111; m_l75p = 0; m_l75prev = 0;
      m_tprev = 0; m_tarm = 0; m_tp = 0;
      return;
    end
    if (ack || iclr) m_ien = 0; else if (iset) m_ien = 1;
    if (mwr) m_mask = mdat;
    rise = rq_75 && !m_l75prev;
    if (rise) m_l75p = 1; else if (rclr || (ack && e == 3'd4)) m_l75p = 0;
    m_l75prev = rq_75;
    fire = m_tarm && rq_trap;
    m_tarm = rq_trap && !m_tprev;
    m_tprev = rq_trap;
    if (fire) m_tp = 1; else if (ack && e == 3'd5) m_tp = 0;
  endtask

  // One cycle: inputs already set; check, clock, clear strobes.
  task automatic cyc(input string tag);
    #1;
    chk(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    mwr = 0; iset = 0; iclr = 0; rclr = 0; ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc("R9"); cyc("R9");
    rst = 0;
    cyc("R9");                          // R9: reset state reads 0
    rq_55 = 1; iset = 1; cyc("R9");     // mask all set from reset
    cyc("R9");                          // enabled, 5.5 still masked
    rq_55 = 0; rq_gen = 1; iclr = 1; cyc("R2");
    cyc("R2");                          // R2: enable clear hides general request
    iset = 1; cyc("R2");
    cyc("R2");                          // now code 1
    mwr = 1; mdat = 3'b000; rq_55 = 1; rq_65 = 1; cyc("R1");
    cyc("R1");                          // R1: 6.5 wins -> 3
    mwr = 1; mdat = 3'b010; cyc("R4");
    cyc("R4");                          // R4: 6.5 masked -> 2
    mwr = 1; mdat = 3'b111; cyc("R4");
    cyc("R4");                          // R4: general not maskable -> 1
    rq_gen = 0; rq_55 = 0; rq_65 = 0;
    rq_75 = 1; cyc("R5");               // edge captured while masked
    cyc("R5");
    mwr = 1; mdat = 3'b000; cyc("R5");
    rq_75 = 0; cyc("R5");               // R5: held after input drops -> 4
    rclr = 1; cyc("R6");
    cyc("R6");                          // R6: discarded -> 0
    rclr = 1; rq_75 = 1; cyc("R6");     // discard and capture together
    cyc("R6");                          // R6: capture wins -> 4
    ack = 1; iset = 1; rq_75 = 0; cyc("R8");
    cyc("R8");                          // R8: ack beats ien_set -> 0
    iset = 1; cyc("R8");
    cyc("R8");                          // 7.5 was cleared by ack -> 0
    rq_75 = 1; cyc("R5"); rq_75 = 0; cyc("R5");
    ack = 1; rq_75 = 1; cyc("R6");      // ack of 4 with a new edge
    iset = 1; rq_75 = 0; cyc("R6");
    cyc("R6");                          // R6: still 4
    rclr = 1; iclr = 1; mwr = 1; mdat = 3'b111; cyc("R3");
    rq_trap = 1; cyc("R7"); rq_trap = 0; cyc("R7");
    cyc("R7"); cyc("R7");               // R7: glitch never pending -> 0
    rq_trap = 1; cyc("R7"); cyc("R7");
    cyc("R3");                          // R3: trap with enable off and mask set -> 5
    rq_trap = 0; cyc("R7");             // R7: still pending after drop
    ack = 1; cyc("R8");
    cyc("R8");                          // R8: trap cleared -> 0

    void'($urandom(32'd4242));
    for (int n = 0; n < 3000; n++) begin
      rq_gen  = ($urandom % 4) == 0;
      rq_55   = ($urandom % 4) == 0;
      rq_65   = ($urandom % 4) == 0;
      if (($urandom % 3) == 0) rq_75 = ~rq_75;
      if (($urandom % 5) == 0) rq_trap = ~rq_trap;
      ack  = ($urandom % 6) == 0;
      iset = ($urandom % 3) == 0;
      iclr = ($urandom % 16) == 0;
      rclr = ($urandom % 12) == 0;
      mwr  = ($urandom % 10) == 0;
      mdat = 3'($urandom);
      rst  = ($urandom % 500) == 0;
      cyc("R1");
      rst = 0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule